// File: doc/BRIEF.md
# Pipeline Hazard and Forwarding Unit

This unit is the hazard control for an in-order integer pipeline with five stages: fetch, decode with register read, execute, memory and writeback. It reads register numbers and a few control bits from the instructions in decode, execute, memory and writeback. From these it drives the operand bypass selects for the ALU and the store-data bypass in the memory stage. It also drives the bypass select for the zero comparator used by branches, and a stall that holds the PC and the fetch/decode register while a no-operation enters execute.

Registers are read only in decode and written only in writeback. Because of this, read-after-write is the only hazard the unit has to handle. Branches compare one register with zero in decode and have a single delay slot. The unit therefore never squashes anything. It must, however, forward into the decode comparator and hold a branch until its operand can be reached there.

The register file is write-through. A value written in writeback is therefore visible to a decode read in the same cycle. The unit is purely combinational. Its clock and reset serve only the checks that are built into it.

Top module: `hazard_fwd_unit`

## Requirements
- R1: A destination register number of 0 never matches a source. It causes no forwarding and no stall, whatever its write enable.
- R2: Each execute-stage operand select is encoded as 0 for the register-read value, 1 for the memory-stage ALU result and 2 for the writeback value. It is 1 when the memory-stage instruction writes the used source and is not a load. It is 2 when only the writeback instruction writes that source. It is 0 when the source is unused or no write enable is set.
- R3: When both the memory-stage and the writeback-stage instructions write the same source, the select is 1, so the younger value wins.
- R4: When a load in the memory stage writes an execute-stage source, that select is 0, even if writeback also matches.
- R5: A load in execute whose destination is a used decode source stalls for exactly one cycle. The decode sources checked are the first source, and the second source unless the decode instruction is a store.
- R6: A store whose data register is loaded by the instruction just ahead of it does not stall. In the memory stage, the store-data select (1 = take the writeback value) is 1 when writeback writes the store's data register.
- R7: A branch in decode whose register is written by a non-load in execute stalls for one cycle. The comparator select (1 = memory-stage ALU result, 0 = register read) is then 1.
- R8: A branch whose register is loaded by the instruction in execute stalls for two cycles. If that loading instruction is in memory, the branch stalls for one cycle.
- R9: A branch whose register is written only in writeback, or by no instruction in flight, does not stall, and its comparator select is 0.
- R10: The stall and the bubble outputs are asserted together, in the same cycle as the condition that causes them, and both are low with an idle pipeline.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the built-in checks |
| rst_n | input | 1 | Active-low reset for the built-in checks |
| id_rs1 | input | AW | Decode first source register |
| id_rs2 | input | AW | Decode second source register |
| id_rs1_used | input | 1 | Decode reads its first source |
| id_rs2_used | input | 1 | Decode reads its second source |
| id_is_store | input | 1 | Decode instruction is a store (second source is data) |
| id_is_branch | input | 1 | Decode instruction is a zero-test branch on its first source |
| ex_rs1 | input | AW | Execute first source register |
| ex_rs2 | input | AW | Execute second source register |
| ex_rs1_used | input | 1 | Execute reads its first source |
| ex_rs2_used | input | 1 | Execute reads its second source |
| ex_rd | input | AW | Execute destination register |
| ex_wr_en | input | 1 | Execute instruction writes a register |
| ex_is_load | input | 1 | Execute instruction is a load |
| mem_rd | input | AW | Memory-stage destination register |
| mem_wr_en | input | 1 | Memory-stage instruction writes a register |
| mem_is_load | input | 1 | Memory-stage instruction is a load |
| mem_is_store | input | 1 | Memory-stage instruction is a store |
| mem_rs2 | input | AW | Memory-stage store data register |
| wb_rd | input | AW | Writeback destination register |
| wb_wr_en | input | 1 | Writeback instruction writes a register |
| alu_a_sel | output | 2 | First ALU operand source select |
| alu_b_sel | output | 2 | Second ALU operand / store data source select |
| br_src_sel | output | 1 | Decode comparator takes the memory-stage ALU result |
| st_data_sel | output | 1 | Memory-stage store data takes the writeback value |
| stall_fe | output | 1 | Hold PC and the fetch/decode register |
| bubble_ex | output | 1 | Load a no-operation with cleared write enable into execute |

## Verification
The hardest case to reach is a branch that waits on a load. Such a branch must stall in two consecutive cycles that have different causes. In the first, the load is in execute. In the second, the load is in memory and the bubble sits in execute. Only then does the branch go ahead, with the comparator reading the register file. A bench that just sets the stage inputs never produces that second cycle the way a real pipeline would. The bench therefore feeds short instruction sequences through a behavioural model of the pipeline registers. That model obeys the unit's own stall and bubble outputs, and the bench counts stall cycles and bypass-select cycles over each sequence. Single-cycle priority cases, such as the younger-wins rule and a load shadowing an older writer, are set up directly on the stage inputs.

// File: rtl/hfu_pkg.sv
package hfu_pkg;
  typedef enum logic [1:0] {
    SRC_RF    = 2'd0,
    SRC_EXMEM = 2'd1,
    SRC_MEMWB = 2'd2
  } fwd_src_e;
endpackage

// File: rtl/hfu_operand_bypass.sv
module hfu_operand_bypass #(
  parameter int unsigned AW = 5
) (
  input  logic [AW-1:0]     src,
  input  logic              used,
  input  logic [AW-1:0]     exm_rd,
  input  logic              exm_we,
  input  logic              exm_load,
  input  logic [AW-1:0]     mwb_rd,
  input  logic              mwb_we,
  output hfu_pkg::fwd_src_e sel
);
  localparam logic [AW-1:0] ZERO_REG = '0;

  logic exm_hit;
  logic mwb_hit;

  always_comb begin
    exm_hit = used && exm_we && (exm_rd != ZERO_REG) && (exm_rd == src);
    mwb_hit = used && mwb_we && (mwb_rd != ZERO_REG) && (mwb_rd == src);
    // younger stage shadows older; a load's EX/MEM slot holds an address
    if (exm_hit)      sel = exm_load ? hfu_pkg::SRC_RF : hfu_pkg::SRC_EXMEM;
    else if (mwb_hit) sel = hfu_pkg::SRC_MEMWB;
    else              sel = hfu_pkg::SRC_RF;
  end
endmodule

// File: rtl/hfu_load_use.sv
module hfu_load_use #(
  parameter int unsigned AW = 5
) (
  input  logic [AW-1:0] id_rs1,
  input  logic          id_rs1_used,
  input  logic [AW-1:0] id_rs2,
  input  logic          id_rs2_used,
  input  logic          id_is_store,
  input  logic [AW-1:0] ex_rd,
  input  logic          ex_we,
  input  logic          ex_load,
  output logic          hazard
);
  localparam logic [AW-1:0] ZERO_REG = '0;

  logic ld_valid;
  logic hit1;
  logic hit2;

  always_comb begin
    ld_valid = ex_load && ex_we && (ex_rd != ZERO_REG);
    hit1     = id_rs1_used && (id_rs1 == ex_rd);
    // store data is consumed in memory stage, reached by the late bypass
    hit2     = id_rs2_used && !id_is_store && (id_rs2 == ex_rd);
    hazard   = ld_valid && (hit1 || hit2);
  end
endmodule

// File: rtl/hfu_branch_guard.sv
module hfu_branch_guard #(
  parameter int unsigned AW = 5
) (
  input  logic [AW-1:0] id_rs1,
  input  logic          id_is_branch,
  input  logic [AW-1:0] ex_rd,
  input  logic          ex_we,
  input  logic [AW-1:0] mem_rd,
  input  logic          mem_we,
  input  logic          mem_load,
  output logic          hazard,
  output logic          take_exm
);
  localparam logic [AW-1:0] ZERO_REG = '0;

  logic ex_hit;
  logic mem_hit;

  always_comb begin
    ex_hit   = id_is_branch && ex_we && (ex_rd != ZERO_REG) && (ex_rd == id_rs1);
    mem_hit  = id_is_branch && mem_we && (mem_rd != ZERO_REG) && (mem_rd == id_rs1);
    hazard   = ex_hit || (mem_hit && mem_load);
    take_exm = mem_hit && !mem_load && !ex_hit;
  end
endmodule

// File: rtl/hazard_fwd_unit.sv
module hazard_fwd_unit #(
  parameter int unsigned AW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] id_rs1,
  input  logic [AW-1:0] id_rs2,
  input  logic          id_rs1_used,
  input  logic          id_rs2_used,
  input  logic          id_is_store,
  input  logic          id_is_branch,
  input  logic [AW-1:0] ex_rs1,
  input  logic [AW-1:0] ex_rs2,
  input  logic          ex_rs1_used,
  input  logic          ex_rs2_used,
  input  logic [AW-1:0] ex_rd,
  input  logic          ex_wr_en,
  input  logic          ex_is_load,
  input  logic [AW-1:0] mem_rd,
  input  logic          mem_wr_en,
  input  logic          mem_is_load,
  input  logic          mem_is_store,
  input  logic [AW-1:0] mem_rs2,
  input  logic [AW-1:0] wb_rd,
  input  logic          wb_wr_en,
  output logic [1:0]    alu_a_sel,
  output logic [1:0]    alu_b_sel,
  output logic          br_src_sel,
  output logic          st_data_sel,
  output logic          stall_fe,
  output logic          bubble_ex
);
  localparam int unsigned   NUM_OPS  = 2;
  localparam logic [AW-1:0] ZERO_REG = '0;

  logic [AW-1:0]     op_src  [NUM_OPS];
  logic              op_used [NUM_OPS];
  hfu_pkg::fwd_src_e op_sel  [NUM_OPS];

  assign op_src[0]  = ex_rs1;
  assign op_src[1]  = ex_rs2;
  assign op_used[0] = ex_rs1_used;
  assign op_used[1] = ex_rs2_used;

  for (genvar g = 0; g < NUM_OPS; g++) begin : g_op
    hfu_operand_bypass #(.AW(AW)) u_byp (
      .src      (op_src[g]),
      .used     (op_used[g]),
      .exm_rd   (mem_rd),
      .exm_we   (mem_wr_en),
      .exm_load (mem_is_load),
      .mwb_rd   (wb_rd),
      .mwb_we   (wb_wr_en),
      .sel      (op_sel[g])
    );
  end

  assign alu_a_sel = op_sel[0];
  assign alu_b_sel = op_sel[1];

  logic lu_hazard;
  logic br_hazard;
  logic br_exm;

  hfu_load_use #(.AW(AW)) u_lu (
    .id_rs1      (id_rs1),
    .id_rs1_used (id_rs1_used),
    .id_rs2      (id_rs2),
    .id_rs2_used (id_rs2_used),
    .id_is_store (id_is_store),
    .ex_rd       (ex_rd),
    .ex_we       (ex_wr_en),
    .ex_load     (ex_is_load),
    .hazard      (lu_hazard)
  );

  hfu_branch_guard #(.AW(AW)) u_br (
    .id_rs1       (id_rs1),
    .id_is_branch (id_is_branch),
    .ex_rd        (ex_rd),
    .ex_we        (ex_wr_en),
    .mem_rd       (mem_rd),
    .mem_we       (mem_wr_en),
    .mem_load     (mem_is_load),
    .hazard       (br_hazard),
    .take_exm     (br_exm)
  );

  logic hold;

  always_comb begin
    hold        = lu_hazard || br_hazard;
    stall_fe    = hold;
    bubble_ex   = hold;
    br_src_sel  = br_exm;
    st_data_sel = mem_is_store && wb_wr_en && (wb_rd != ZERO_REG) && (wb_rd == mem_rs2);
  end

  // R1: zero destinations everywhere leave every output idle
  a_r1_zero_dest_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_rd == ZERO_REG && mem_rd == ZERO_REG && wb_rd == ZERO_REG) |->
    (!stall_fe && alu_a_sel == 2'd0 && alu_b_sel == 2'd0 && !br_src_sel && !st_data_sel));

  // R3: younger memory-stage ALU writer beats writeback
  a_r3_younger_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_rs1_used && ex_rs1 != ZERO_REG && mem_wr_en && !mem_is_load && mem_rd == ex_rs1 &&
     wb_wr_en && wb_rd == ex_rs1) |-> (alu_a_sel == 2'd1));

  // R5: load in execute feeding decode first source holds the front end
  a_r5_load_use_stalls: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_is_load && ex_wr_en && ex_rd != ZERO_REG && id_rs1_used && id_rs1 == ex_rd) |->
    (stall_fe && bubble_ex));

  // R6: a store using only its data register never stalls
  a_r6_store_data_no_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (id_is_store && !id_rs1_used && !id_is_branch) |-> !stall_fe);

  // R7: branch on an execute-stage writer stalls and does not bypass
  a_r7_branch_on_ex_writer: assert property (@(posedge clk) disable iff (!rst_n)
    (id_is_branch && ex_wr_en && ex_rd != ZERO_REG && ex_rd == id_rs1) |->
    (stall_fe && !br_src_sel));

  // R8: branch on a load still in memory stage stalls
  a_r8_branch_on_mem_load: assert property (@(posedge clk) disable iff (!rst_n)
    (id_is_branch && mem_wr_en && mem_is_load && mem_rd != ZERO_REG && mem_rd == id_rs1) |->
    stall_fe);

  // R10: stall and bubble always move together
  a_r10_stall_bubble_pair: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({stall_fe, bubble_ex}) != 1);
endmodule

// File: tb/hazard_fwd_unit_tb.sv
module hazard_fwd_unit_tb_top;
  typedef struct packed {
    logic [4:0] rd;
    logic       we;
    logic       ld;
    logic       st;
    logic       br;
    logic [4:0] rs1;
    logic [4:0] rs2;
    logic       u1;
    logic       u2;
  } ins_t;

  localparam ins_t NOP = '0;

  logic clk;
  logic rst_n;
  logic [4:0] id_rs1, id_rs2, ex_rs1, ex_rs2, ex_rd, mem_rd, mem_rs2, wb_rd;
  logic id_rs1_used, id_rs2_used, id_is_store, id_is_branch;
  logic ex_rs1_used, ex_rs2_used, ex_wr_en, ex_is_load;
  logic mem_wr_en, mem_is_load, mem_is_store, wb_wr_en;
  logic [1:0] alu_a_sel, alu_b_sel;
  logic br_src_sel, st_data_sel, stall_fe, bubble_ex;

  int nchk = 0;
  int nerr = 0;
  bit done = 0;

  hazard_fwd_unit #(.AW(5)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .id_rs1(id_rs1), .id_rs2(id_rs2), .id_rs1_used(id_rs1_used), .id_rs2_used(id_rs2_used),
    .id_is_store(id_is_store), .id_is_branch(id_is_branch),
    .ex_rs1(ex_rs1), .ex_rs2(ex_rs2), .ex_rs1_used(ex_rs1_used), .ex_rs2_used(ex_rs2_used),
    .ex_rd(ex_rd), .ex_wr_en(ex_wr_en), .ex_is_load(ex_is_load),
    .mem_rd(mem_rd), .mem_wr_en(mem_wr_en), .mem_is_load(mem_is_load),
    .mem_is_store(mem_is_store), .mem_rs2(mem_rs2),
    .wb_rd(wb_rd), .wb_wr_en(wb_wr_en),
    .alu_a_sel(alu_a_sel), .alu_b_sel(alu_b_sel), .br_src_sel(br_src_sel),
    .st_data_sel(st_data_sel), .stall_fe(stall_fe), .bubble_ex(bubble_ex)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic ins_t mk_alu(input int rd, input int a, input int b);
    ins_t i = NOP;
    i.rd = 5'(rd); i.we = 1'b1; i.rs1 = 5'(a); i.rs2 = 5'(b); i.u1 = 1'b1; i.u2 = 1'b1;
    return i;
  endfunction

  function automatic ins_t mk_ld(input int rd, input int base);
    ins_t i = NOP;
    i.rd = 5'(rd); i.we = 1'b1; i.ld = 1'b1; i.rs1 = 5'(base); i.u1 = 1'b1;
    return i;
  endfunction

  function automatic ins_t mk_st(input int base, input int data);
    ins_t i = NOP;
    i.st = 1'b1; i.rs1 = 5'(base); i.rs2 = 5'(data); i.u1 = 1'b1; i.u2 = 1'b1;
    return i;
  endfunction

  function automatic ins_t mk_br(input int r);
    ins_t i = NOP;
    i.br = 1'b1; i.rs1 = 5'(r); i.u1 = 1'b1;
    return i;
  endfunction

  task automatic drive(input ins_t id, input ins_t ex, input ins_t mem, input ins_t wb);
    id_rs1 = id.rs1; id_rs2 = id.rs2; id_rs1_used = id.u1; id_rs2_used = id.u2;
    id_is_store = id.st; id_is_branch = id.br;
    ex_rs1 = ex.rs1; ex_rs2 = ex.rs2; ex_rs1_used = ex.u1; ex_rs2_used = ex.u2;
    ex_rd = ex.rd; ex_wr_en = ex.we; ex_is_load = ex.ld;
    mem_rd = mem.rd; mem_wr_en = mem.we; mem_is_load = mem.ld; mem_is_store = mem.st;
    mem_rs2 = mem.rs2;
    wb_rd = wb.rd; wb_wr_en = wb.we;
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic set_and_settle(input ins_t id, input ins_t ex, input ins_t mem, input ins_t wb);
    @(negedge clk);
    drive(id, ex, mem, wb);
    #1;
  endtask

  // behavioural pipeline: runs a program, obeys stall/bubble, counts events
  task automatic run_prog(input ins_t p0, input ins_t p1, input ins_t p2, input int n,
                          output int stalls, output int brfwd, output int stfwd);
    ins_t prog [3];
    ins_t s_id, s_ex, s_mem, s_wb;
    int pc;
    prog[0] = p0; prog[1] = p1; prog[2] = p2;
    s_ex = NOP; s_mem = NOP; s_wb = NOP;
    pc = 0; stalls = 0; brfwd = 0; stfwd = 0;
    for (int cyc = 0; cyc < 10; cyc++) begin
      s_id = (pc < n) ? prog[pc] : NOP;
      @(negedge clk);
      drive(s_id, s_ex, s_mem, s_wb);
      #1;
      if (stall_fe)    stalls++;
      if (br_src_sel)  brfwd++;
      if (st_data_sel) stfwd++;
      @(posedge clk);
      s_wb = s_mem;
      s_mem = s_ex;
      if (bubble_ex) s_ex = NOP;
      else begin
        s_ex = s_id;
        if (pc < n) pc++;
      end
    end
  endtask

  task automatic t_reset_idle;
    set_and_settle(NOP, NOP, NOP, NOP);
    chk("R10 idle stall", stall_fe, 0);
    chk("R10 idle bubble", bubble_ex, 0);
    chk("R2 idle a_sel", alu_a_sel, 0);
    chk("R2 idle b_sel", alu_b_sel, 0);
  endtask

  task automatic t_alu_bypass;
    set_and_settle(NOP, mk_alu(9, 7, 8), mk_alu(7, 1, 1), mk_alu(8, 1, 1));
    chk("R2 a from EX/MEM", alu_a_sel, 1);
    chk("R2 b from MEM/WB", alu_b_sel, 2);
    begin
      ins_t m = mk_alu(7, 1, 1);
      m.we = 1'b0;
      set_and_settle(NOP, mk_alu(9, 7, 8), m, NOP);
      chk("R2 write enable low ignored", alu_a_sel, 0);
    end
    begin
      ins_t e = mk_alu(9, 7, 8);
      e.u1 = 1'b0;
      set_and_settle(NOP, e, mk_alu(7, 1, 1), NOP);
      chk("R2 unused source ignored", alu_a_sel, 0);
    end
  endtask

  task automatic t_priority;
    set_and_settle(NOP, mk_alu(9, 7, 8), mk_alu(7, 1, 1), mk_alu(7, 2, 2));
    chk("R3 younger wins", alu_a_sel, 1);
    set_and_settle(NOP, mk_st(3, 8), mk_ld(8, 1), mk_alu(8, 1, 1));
    chk("R4 load in memory shadows writeback", alu_b_sel, 0);
  endtask

  task automatic t_zero_reg;
    set_and_settle(mk_alu(6, 0, 0), mk_alu(0, 0, 0), mk_alu(0, 1, 1), mk_alu(0, 2, 2));
    chk("R1 a_sel on r0", alu_a_sel, 0);
    chk("R1 b_sel on r0", alu_b_sel, 0);
    set_and_settle(mk_alu(6, 0, 0), mk_ld(0, 1), NOP, NOP);
    chk("R1 load to r0 no stall", stall_fe, 0);
  endtask

  task automatic t_load_use_direct;
    set_and_settle(mk_alu(6, 1, 5), mk_ld(5, 2), NOP, NOP);
    chk("R5 second source load-use stall", stall_fe, 1);
    chk("R10 bubble with stall", bubble_ex, 1);
    set_and_settle(mk_st(1, 5), mk_ld(5, 2), NOP, NOP);
    chk("R6 store data behind load no stall", stall_fe, 0);
  endtask

  task automatic t_branch_direct;
    set_and_settle(mk_br(4), mk_alu(9, 1, 2), NOP, NOP);
    chk("R9 independent branch stall", stall_fe, 0);
    chk("R9 independent branch sel", br_src_sel, 0);
    set_and_settle(mk_br(4), NOP, NOP, mk_alu(4, 1, 2));
    chk("R9 writeback writer no stall", stall_fe, 0);
    chk("R9 writeback writer sel", br_src_sel, 0);
    set_and_settle(mk_br(4), NOP, mk_alu(4, 1, 2), NOP);
    chk("R7 memory ALU writer bypass", br_src_sel, 1);
  endtask

  task automatic t_sequences;
    int s, b, w;
    run_prog(mk_ld(5, 1), mk_alu(6, 5, 2), NOP, 2, s, b, w);
    chk("R5 load-use stall cycles", s, 1);
    run_prog(mk_ld(3, 1), mk_br(3), NOP, 2, s, b, w);
    chk("R8 branch after load stall cycles", s, 2);
    chk("R8 branch after load no comparator bypass", b, 0);
    run_prog(mk_ld(3, 1), mk_alu(9, 1, 2), mk_br(3), 3, s, b, w);
    chk("R8 branch two behind load stall cycles", s, 1);
    run_prog(mk_alu(3, 1, 2), mk_br(3), NOP, 2, s, b, w);
    chk("R7 branch after ALU stall cycles", s, 1);
    chk("R7 branch after ALU bypass cycles", b, 1);
    run_prog(mk_ld(4, 1), mk_st(2, 4), NOP, 2, s, b, w);
    chk("R6 load-store stall cycles", s, 0);
    chk("R6 store data bypass cycles", w, 1);
    run_prog(mk_ld(0, 1), mk_alu(6, 0, 0), mk_br(0), 3, s, b, w);
    chk("R1 r0 sequence stall cycles", s, 0);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  endtask

  initial begin
    rst_n = 1'b0;
    drive(NOP, NOP, NOP, NOP);
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset_idle();
    t_alu_bypass();
    t_priority();
    t_zero_reg();
    t_load_use_direct();
    t_branch_direct();
    t_sequences();
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    nchk++;
    nerr++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end
endmodule